// File: doc/BRIEF.md
# Single-Precision Mantissa Rounder

This block rounds a wide binary significand down to single-precision width. It accepts a sign, a signed exponent and a 53-bit significand whose leading bit is explicit. It also accepts three low-order bits (guard, round, sticky) that an earlier denormalizing shift pushed out of the significand. A two-bit mode selects the rounding direction. The block keeps the top 24 significand bits and decides from the dropped bits whether to add one at the last kept position. It then returns the adjusted exponent, the rounded significand with every dropped bit cleared, and two status bits: one says the value was incremented and the other says the result is inexact.

A conversion datapath places this unit after its classify and shift stages and before its packing stage. Overflow and underflow detection, operand classes and result packing all belong to that datapath. Inputs are captured at a clock edge, and the results appear on the outputs one cycle later from a single result register.

Top module: `sp_mant_rounder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: The outputs reflect the inputs that were present at the previous rising clock edge. Significand bits are numbered from the MSB, so bit 0 is `in_sig[52]`. The kept field is bits 0..23 (`out_sig[52:29]`). Bits 24..52 (`out_sig[28:0]`) are always zero.
- R3: Mode 2'b00 rounds to nearest with ties to even. The lsb is bit 23 (`in_sig[29]`), the guard is bit 24 (`in_sig[28]`) and the round bit is bit 25 (`in_sig[27]`). Sticky is the OR of bits 26..52 (`in_sig[26:0]`) with `in_g`, `in_r` and `in_x`. The field is incremented when guard and lsb are both set, or when guard is set together with round or sticky.
- R4: Mode 2'b01 truncates. The kept field and the exponent pass through unchanged, and `out_fr` stays 0.
- R5: Mode 2'b10 increments a positive value, and mode 2'b11 increments a negative value, whenever any of guard, round or sticky is set. The opposite sign is never incremented in these modes.
- R6: An increment that carries out of an all-ones kept field leaves the field as a single 1 followed by 23 zeros, and the exponent grows by one. Without that carry the exponent is unchanged. The exponent is 13-bit two's complement and wraps modulo 2^13.
- R7: `out_fr` is 1 exactly when the increment was applied.
- R8: `out_fi` is 1 exactly when guard, round or sticky (including the three external bits) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_exp | input | 13 | Unbiased exponent, two's complement |
| in_sig | input | 53 | Significand, MSB is the leading bit |
| in_g | input | 1 | Guard bit from a prior right shift |
| in_r | input | 1 | Round bit from a prior right shift |
| in_x | input | 1 | Sticky bit from a prior right shift |
| in_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_exp | output | 13 | Exponent after rounding carry |
| out_sig | output | 53 | Rounded significand, low 29 bits zero |
| out_fr | output | 1 | Increment applied |
| out_fi | output | 1 | Result inexact |

## Verification
The sweeps aim at exact ties with an even and an odd lsb. A design that breaks ties away from zero, or that ignores the lsb, would round even ties upward and fail these cases. The sweeps also cover values whose only nonzero dropped bits are the external guard, round and sticky inputs. A design that leaves those inputs out of sticky would truncate such values and would clear the inexact flag.

All-ones fields are driven at an exponent of +4095 to reach both the carry and the exponent wrap. A design that drops the carry would return a zero field or a stale exponent. Each case is repeated for both signs under the two directed modes, which would expose a design that swaps the sign test.

// File: rtl/sprnd_pkg.sv
package sprnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TRUNC   = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

endpackage

// File: rtl/sprnd_sticky.sv
module sprnd_sticky #(
    parameter int LOW_W = 27,
    parameter int EXT_W = 3
) (
    input  logic [LOW_W-1:0] low_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic             sticky_o
);
    always_comb begin
        sticky_o = (|low_i) | (|ext_i);
    end
endmodule

// File: rtl/sprnd_decide.sv
module sprnd_decide
    import sprnd_pkg::*;
(
    input  logic   sign_i,
    input  rmode_e mode_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   round_i,
    input  logic   sticky_i,
    output logic   inc_o
);
    logic below_any;

    always_comb begin
        below_any = guard_i | round_i | sticky_i;
        unique case (mode_i)
            RM_NEAREST: inc_o = guard_i & (lsb_i | round_i | sticky_i);
            RM_TRUNC:   inc_o = 1'b0;
            RM_UP:      inc_o = ~sign_i & below_any;
            RM_DOWN:    inc_o = sign_i & below_any;
            default:    inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sprnd_incr.sv
module sprnd_incr #(
    parameter int KEEP_W = 24
) (
    input  logic [KEEP_W-1:0] keep_i,
    input  logic              inc_i,
    output logic [KEEP_W-1:0] keep_o,
    output logic              carry_o
);
    logic [KEEP_W:0] sum;

    always_comb begin
        sum     = {1'b0, keep_i} + {{KEEP_W{1'b0}}, inc_i};
        carry_o = sum[KEEP_W];
        keep_o  = carry_o ? {1'b1, sum[KEEP_W-1:1]} : sum[KEEP_W-1:0];
    end
endmodule

// File: rtl/sp_mant_rounder.sv
module sp_mant_rounder
    import sprnd_pkg::*;
#(
    parameter int SIG_W  = 53,
    parameter int KEEP_W = 24,
    parameter int EXP_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              in_g,
    input  logic              in_r,
    input  logic              in_x,
    input  logic [1:0]        in_mode,
    output logic [EXP_W-1:0]  out_exp,
    output logic [SIG_W-1:0]  out_sig,
    output logic              out_fr,
    output logic              out_fi
);
    localparam int DROP_W = SIG_W - KEEP_W;
    localparam int STK_W  = DROP_W - 2;
    localparam int LSB_IX = DROP_W;
    localparam int GRD_IX = DROP_W - 1;
    localparam int RND_IX = DROP_W - 2;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic             fr;
        logic             fi;
    } res_t;

    res_t res_d, res_q;

    logic              sticky;
    logic              inc;
    logic              carry;
    logic [KEEP_W-1:0] keep_new;

    sprnd_sticky #(.LOW_W(STK_W), .EXT_W(3)) u_sticky (
        .low_i    (in_sig[STK_W-1:0]),
        .ext_i    ({in_g, in_r, in_x}),
        .sticky_o (sticky)
    );

    sprnd_decide u_decide (
        .sign_i   (in_sign),
        .mode_i   (rmode_e'(in_mode)),
        .lsb_i    (in_sig[LSB_IX]),
        .guard_i  (in_sig[GRD_IX]),
        .round_i  (in_sig[RND_IX]),
        .sticky_i (sticky),
        .inc_o    (inc)
    );

    sprnd_incr #(.KEEP_W(KEEP_W)) u_incr (
        .keep_i  (in_sig[SIG_W-1 -: KEEP_W]),
        .inc_i   (inc),
        .keep_o  (keep_new),
        .carry_o (carry)
    );

    always_comb begin
        res_d     = res_q;
        res_d.exp = in_exp + {{(EXP_W-1){1'b0}}, carry};
        res_d.sig = {keep_new, {DROP_W{1'b0}}};
        res_d.fr  = inc;
        res_d.fi  = in_sig[GRD_IX] | in_sig[RND_IX] | sticky;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_exp = res_q.exp;
    assign out_sig = res_q.sig;
    assign out_fr  = res_q.fr;
    assign out_fi  = res_q.fi;

    AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        out_sig[DROP_W-1:0] == '0); // R2

    AST_TRUNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_mode == 2'b01) |=>
        (!out_fr && out_sig[SIG_W-1:DROP_W] == $past(in_sig[SIG_W-1:DROP_W])
         && out_exp == $past(in_exp))); // R4

    AST_UP_NEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_mode == 2'b10 && in_sign) |=> !out_fr); // R5

    AST_DOWN_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_mode == 2'b11 && !in_sign) |=> !out_fr); // R5

    AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_exp == $past(in_exp)) ||
                  (out_exp == EXP_W'($past(in_exp) + 1'b1) && out_sig[SIG_W-1]
                   && out_sig[SIG_W-2:DROP_W] == '0)); // R6

    AST_FR_NEEDS_FI: assert property (@(posedge clk) disable iff (!rst_n)
        out_fr |-> out_fi); // R7

    AST_FI_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_fi == $past((|in_sig[DROP_W-1:0]) | in_g | in_r | in_x)); // R8

endmodule

// File: tb/sim_sp_mant_rounder.sv
`timescale 1ns/1ps
module sim_sp_mant_rounder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_sign = 1'b0;
    logic [12:0] in_exp = '0;
    logic [52:0] in_sig = '0;
    logic        in_g = 1'b0, in_r = 1'b0, in_x = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [12:0] out_exp;
    logic [52:0] out_sig;
    logic        out_fr, out_fi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sp_mant_rounder u0 (
        .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_exp(in_exp),
        .in_sig(in_sig), .in_g(in_g), .in_r(in_r), .in_x(in_x),
        .in_mode(in_mode), .out_exp(out_exp), .out_sig(out_sig),
        .out_fr(out_fr), .out_fi(out_fi)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic run_case(input logic s, input logic [1:0] m, input logic [52:0] sig,
                            input logic g, input logic r, input logic x, input logic [12:0] e);
        logic [29:0] rest;
        logic [24:0] keep, sum;
        logic        inc;
        logic [23:0] nkeep;
        logic [12:0] eexp;
        logic [52:0] esig;
        string       stag;
        rest = {sig[28:0], g | r | x};
        keep = {1'b0, sig[52:29]};
        case (m)
            2'b00: inc = (rest > 30'h2000_0000) || (rest == 30'h2000_0000 && keep[0]);
            2'b01: inc = 1'b0;
            2'b10: inc = !s && rest != 0;
            default: inc = s && rest != 0;
        endcase
        sum = keep + {24'd0, inc};
        if (sum[24]) begin
            nkeep = 24'h80_0000;
            eexp  = e + 13'd1;
        end else begin
            nkeep = sum[23:0];
            eexp  = e;
        end
        esig = {nkeep, 29'd0};
        case (m)
            2'b00: stag = "R3";
            2'b01: stag = "R4";
            default: stag = "R5";
        endcase
        @(negedge clk);
        in_sign = s; in_mode = m; in_sig = sig; in_g = g; in_r = r; in_x = x; in_exp = e;
        @(negedge clk);
        check({stag, " sig"}, {11'd0, out_sig}, {11'd0, esig});
        check("R2 low bits", {35'd0, out_sig[28:0]}, 64'd0);
        check("R6 exp", {51'd0, out_exp}, {51'd0, eexp});
        check("R7 fr", {63'd0, out_fr}, {63'd0, inc});
        check("R8 fi", {63'd0, out_fi}, {63'd0, rest != 0});
    endtask

    function automatic logic [28:0] low_pat(input int k);
        case (k)
            0: return 29'd0;
            1: return 29'h1000_0000;
            2: return 29'h1000_0001;
            3: return 29'h0800_0000;
            4: return 29'd1;
            5: return 29'h1FFF_FFFF;
            default: return 29'($urandom);
        endcase
    endfunction

    function automatic logic [23:0] keep_pat(input int k);
        case (k)
            0: return 24'h80_0000 | 24'($urandom);
            1: return 24'hFF_FFFF;
            2: return 24'h00_0000;
            default: return 24'hFF_FFFE;
        endcase
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        in_sig = '1; in_exp = '1; in_g = 1'b1;
        @(negedge clk);
        check("R1 reset sig", {11'd0, out_sig}, 64'd0);
        check("R1 reset exp", {51'd0, out_exp}, 64'd0);
        check("R1 reset flags", {62'd0, out_fr, out_fi}, 64'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int kk = 0; kk < 4; kk++)
                    for (int lo = 0; lo < 7; lo++)
                        for (int grx = 0; grx < 8; grx++) begin
                            logic [12:0] e;
                            e = (kk == 1 && lo == 5) ? 13'h0FFF : 13'($urandom);
                            run_case(s[0], m[1:0], {keep_pat(kk), low_pat(lo)},
                                     grx[2], grx[1], grx[0], e);
                        end

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] v;
            v = {$urandom, $urandom};
            run_case(v[63], v[62:61], v[52:0], v[60], v[59], v[58], 13'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule